// File: doc/BRIEF.md
# SPI-4.2 Receive Protocol Error Monitor

This block sits beside the receive path of an SPI-4.2 style interface and watches its 16-bit word stream. One word arrives every clock cycle, together with a flag that says whether the word is a control word or a data word. The monitor decodes each control word, tracks the burst, packet and training grammar across words, and raises a one-cycle error pulse for each of five kinds of fault. These faults are a parity failure on a control word, a payload control word directly after another one, data outside an opened burst, start-of-packet words that are too close together, and a damaged training sequence.

An alignment input says when the upstream alignment logic has locked. Training faults are reported only while that input is high. All other checks run from the moment reset is released. Outputs are registered, so every pulse appears in the cycle after the word that caused it. A single word can raise several pulses at once.

Top module: `spi4_rx_monitor`

## Requirements
- R1: While reset is high and in the first cycle after it, all five error outputs are low; the sop spacing history starts saturated, so the first start-of-packet word after reset raises no spacing error.
- R2: A control word is laid out as bit 15 = payload flag (1 = payload, 0 = idle/training), bits 14:13 = end-of-packet status, bit 12 = start-of-packet, bits 11:4 = port, bits 3:0 = parity code. A 16-bit accumulator is cleared after every control word. Each word is folded into it as acc = rotate-left-by-one(acc) XOR word, and a control word takes part with its parity field forced to 4'hF. The expected code bit i is acc[12+i]^acc[8+i]^acc[4+i]^acc[i]. On a mismatch, errDip4 pulses. The training control word 16'h0FFF is not checked.
- R3: A control word with the payload flag set, directly following another such control word, pulses errProto.
- R4: A data word outside a training sequence, when the most recent control word had its payload flag clear (or none has been seen since reset), pulses errBurstStart.
- R5: A control word with the payload and start-of-packet flags both set pulses errSopSpacing when it comes fewer than 8 cycles after the previous such word. A distance of exactly 8 raises no error.
- R6: A run of training control words (16'h0FFF) followed by a data word pulses errTraining on that data word unless the run length was exactly 10.
- R7: Any data word inside a training sequence other than 16'hF000 pulses errTraining.
- R8: A training data run must be exactly 10 words long. The 11th and any later data word pulses errTraining, and so does a control word that ends a run of 1 to 9 training data words.
- R9: errTraining pulses only for words presented while aligned is high. While aligned is low, training sequences are still tracked, so their data words raise no errBurstStart.
- R10: Each error output is a registered pulse in the cycle after the offending word, and several outputs may pulse for the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| aligned | input | 1 | High once the receive path is aligned; enables training checks |
| isCtrl | input | 1 | High when wordIn is a control word |
| wordIn | input | 16 | Received word, one per cycle |
| errDip4 | output | 1 | Control word parity mismatch pulse |
| errProto | output | 1 | Payload control word directly after a payload control word |
| errBurstStart | output | 1 | Data word in a burst that was never opened |
| errSopSpacing | output | 1 | Start-of-packet words fewer than 8 cycles apart |
| errTraining | output | 1 | Corrupted training sequence pulse |

## Verification
The hardest case to reach is a training fault found only at the boundary of a run. Examples are a tenth control word that never arrives, an eleventh data word, or a control word that cuts a data run short. Each depends on two counters and the training state agreeing across twenty or more words. The stimulus builds complete training sequences word by word and changes exactly one run length or one data value in each. It also repeats one faulty sequence with aligned low. Parity on every ordinary control word comes from a bench model of the accumulator, so a single deliberately flipped code bit isolates the parity check. One combined word stacks the parity, protocol and spacing faults together.

// File: rtl/spi4mon_pkg.sv
package spi4mon_pkg;

  typedef struct packed {
    logic       payload;
    logic [1:0] eopStat;
    logic       sop;
    logic [7:0] port;
    logic [3:0] dip;
  } ctrl_word_t;

  typedef struct packed {
    logic dataWord;
    logic accClear;
    logic dipCheck;
    logic sopMark;
  } strobe_t;

  typedef enum logic [1:0] {TR_IDLE, TR_CTRL, TR_DATA} train_e;

  function automatic logic [3:0] foldDip(input logic [15:0] acc);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = acc[12+i] ^ acc[8+i] ^ acc[4+i] ^ acc[i];
    return r;
  endfunction

endpackage

// File: rtl/spi4mon_ctrl.sv
module spi4mon_ctrl
  import spi4mon_pkg::*;
#(
  parameter int          CTRL_RUN   = 10,
  parameter int          DATA_RUN   = 10,
  parameter logic [15:0] TRAIN_CTRL = 16'h0FFF,
  parameter logic [15:0] TRAIN_DATA = 16'hF000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        aligned,
  input  logic        isCtrl,
  input  logic [15:0] wordIn,
  output strobe_t     stb,
  output logic        errProto,
  output logic        errBurstStart,
  output logic        errTraining
);
  localparam int CW = $clog2(CTRL_RUN + 2);
  localparam int DW = $clog2(DATA_RUN + 2);
  localparam logic [CW-1:0] C_EXACT = CW'(CTRL_RUN);
  localparam logic [CW-1:0] C_MAX   = CW'(CTRL_RUN + 1);
  localparam logic [DW-1:0] D_EXACT = DW'(DATA_RUN);
  localparam logic [DW-1:0] D_MAX   = DW'(DATA_RUN + 1);

  ctrl_word_t    cw;
  logic          isTrainCtrl;
  logic          prevPayload, burstOpen;
  train_e        trState;
  logic [CW-1:0] ctrlRun;
  logic [DW-1:0] dataRun;
  logic          protoHit, burstHit, trainHit;

  assign cw          = ctrl_word_t'(wordIn);
  assign isTrainCtrl = isCtrl && (wordIn == TRAIN_CTRL);

  always_comb begin
    stb.dataWord = !isCtrl;
    stb.accClear = isCtrl;
    stb.dipCheck = isCtrl && !isTrainCtrl;
    stb.sopMark  = isCtrl && cw.payload && cw.sop;
  end

  assign protoHit = isCtrl && cw.payload && prevPayload;
  assign burstHit = !isCtrl && (trState == TR_IDLE) && !burstOpen;

  always_comb begin
    trainHit = 1'b0;
    if (isCtrl) begin
      if (trState == TR_DATA && dataRun < D_EXACT) trainHit = 1'b1;
    end else begin
      case (trState)
        TR_CTRL: trainHit = (ctrlRun != C_EXACT) || (wordIn != TRAIN_DATA);
        TR_DATA: trainHit = (wordIn != TRAIN_DATA) || (dataRun >= D_EXACT);
        default: trainHit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevPayload   <= 1'b0;
      burstOpen     <= 1'b0;
      trState       <= TR_IDLE;
      ctrlRun       <= '0;
      dataRun       <= '0;
      errProto      <= 1'b0;
      errBurstStart <= 1'b0;
      errTraining   <= 1'b0;
    end else begin
      errProto      <= protoHit;
      errBurstStart <= burstHit;
      errTraining   <= trainHit && aligned;
      prevPayload   <= isCtrl && cw.payload;
      if (isCtrl) begin
        burstOpen <= cw.payload;
        if (isTrainCtrl) begin
          trState <= TR_CTRL;
          if (trState != TR_CTRL) ctrlRun <= CW'(1);
          else if (ctrlRun != C_MAX) ctrlRun <= ctrlRun + 1'b1;
        end else begin
          trState <= TR_IDLE;
        end
      end else if (trState == TR_CTRL) begin
        trState <= TR_DATA;
        dataRun <= DW'(1);
      end else if (trState == TR_DATA && dataRun != D_MAX) begin
        dataRun <= dataRun + 1'b1;
      end
    end
  end

  assert_proto_payload_pair_R3: assert property (@(posedge clk) disable iff (rst)
    errProto |-> $past(isCtrl && wordIn[15]));

  assert_burst_on_data_R4: assert property (@(posedge clk) disable iff (rst)
    errBurstStart |-> $past(!isCtrl));

  assert_train_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(aligned) |-> !errTraining);

  assert_run_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    (ctrlRun <= C_MAX) && (dataRun <= D_MAX));

endmodule

// File: rtl/spi4mon_dpath.sv
module spi4mon_dpath
  import spi4mon_pkg::*;
#(
  parameter int SOP_GAP = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] wordIn,
  input  strobe_t     stb,
  output logic        errDip4,
  output logic        errSopSpacing
);
  localparam int SW = $clog2(SOP_GAP + 1);
  localparam logic [SW-1:0] GAP = SW'(SOP_GAP);

  logic [15:0]   acc, accNext;
  logic [3:0]    code;
  logic [SW-1:0] sinceSop;

  always_comb begin
    accNext = {acc[14:0], acc[15]} ^ (stb.dataWord ? wordIn : {wordIn[15:4], 4'hF});
    code    = foldDip(accNext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc           <= '0;
      sinceSop      <= GAP;
      errDip4       <= 1'b0;
      errSopSpacing <= 1'b0;
    end else begin
      errDip4       <= stb.dipCheck && (code != wordIn[3:0]);
      errSopSpacing <= stb.sopMark && (sinceSop < GAP);
      acc           <= stb.accClear ? '0 : accNext;
      if (stb.sopMark) sinceSop <= SW'(1);
      else if (sinceSop != GAP) sinceSop <= sinceSop + 1'b1;
    end
  end

  assert_dip_on_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
    errDip4 |-> $past(stb.dipCheck));

  assert_sop_on_mark_R5: assert property (@(posedge clk) disable iff (rst)
    errSopSpacing |-> $past(stb.sopMark));

  assert_sop_window_R5: assert property (@(posedge clk) disable iff (rst)
    (sinceSop >= SW'(1)) && (sinceSop <= GAP));

endmodule

// File: rtl/spi4_rx_monitor.sv
module spi4_rx_monitor
  import spi4mon_pkg::*;
#(
  parameter int          CTRL_RUN   = 10,
  parameter int          DATA_RUN   = 10,
  parameter int          SOP_GAP    = 8,
  parameter logic [15:0] TRAIN_CTRL = 16'h0FFF,
  parameter logic [15:0] TRAIN_DATA = 16'hF000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        aligned,
  input  logic        isCtrl,
  input  logic [15:0] wordIn,
  output logic        errDip4,
  output logic        errProto,
  output logic        errBurstStart,
  output logic        errSopSpacing,
  output logic        errTraining
);
  strobe_t stb;

  spi4mon_ctrl #(
    .CTRL_RUN(CTRL_RUN), .DATA_RUN(DATA_RUN),
    .TRAIN_CTRL(TRAIN_CTRL), .TRAIN_DATA(TRAIN_DATA)
  ) uCtrl (
    .clk(clk), .rst(rst), .aligned(aligned), .isCtrl(isCtrl), .wordIn(wordIn),
    .stb(stb), .errProto(errProto), .errBurstStart(errBurstStart),
    .errTraining(errTraining)
  );

  spi4mon_dpath #(.SOP_GAP(SOP_GAP)) uDpath (
    .clk(clk), .rst(rst), .wordIn(wordIn), .stb(stb),
    .errDip4(errDip4), .errSopSpacing(errSopSpacing)
  );

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !(errDip4 || errProto || errBurstStart || errSopSpacing || errTraining));

endmodule

// File: tb/tb_spi4_rx_monitor.sv
module tb_spi4_rx_monitor;
  logic clk = 1'b0, rst = 1'b1, aligned = 1'b0, isCtrl = 1'b0;
  logic [15:0] wordIn = '0;
  logic errDip4, errProto, errBurstStart, errSopSpacing, errTraining;
  logic alignNext = 1'b1;

  always #10 clk = ~clk;

  spi4_rx_monitor dut (
    .clk(clk), .rst(rst), .aligned(aligned), .isCtrl(isCtrl), .wordIn(wordIn),
    .errDip4(errDip4), .errProto(errProto), .errBurstStart(errBurstStart),
    .errSopSpacing(errSopSpacing), .errTraining(errTraining)
  );

  int checks = 0, fails = 0;
  logic [4:0] expQ[$];
  string      tagQ[$];

  // reference model state
  logic [15:0] mAcc = '0;
  bit mPrevPay = 0, mBurst = 0;
  int mTr = 0, mCRun = 0, mDRun = 0, mSince = 8;

  function automatic logic [15:0] rotl(input logic [15:0] a);
    return {a[14:0], a[15]};
  endfunction

  function automatic logic [3:0] fold(input logic [15:0] a);
    return a[15:12] ^ a[11:8] ^ a[7:4] ^ a[3:0];
  endfunction

  task automatic putWord(input bit c, input logic [15:0] w, input string tag);
    logic [4:0] e;
    bit tErr;
    @(negedge clk);
    rst = 1'b0; aligned = alignNext; isCtrl = c; wordIn = w;
    e = '0; tErr = 0;
    if (c) begin
      if (w != 16'h0FFF && fold(rotl(mAcc) ^ {w[15:4], 4'hF}) != w[3:0]) e[4] = 1;
      mAcc = '0;
      if (w[15] && mPrevPay) e[3] = 1;
      mPrevPay = w[15]; mBurst = w[15];
      if (w[15] && w[12]) begin
        if (mSince < 8) e[1] = 1;
        mSince = 1;
      end else if (mSince < 8) mSince++;
      if (mTr == 2 && mDRun < 10) tErr = 1;
      if (w == 16'h0FFF) begin
        mCRun = (mTr == 1) ? ((mCRun < 11) ? mCRun + 1 : 11) : 1;
        mTr = 1;
      end else mTr = 0;
    end else begin
      mAcc = rotl(mAcc) ^ w;
      mPrevPay = 0;
      if (mTr == 0) begin
        if (!mBurst) e[2] = 1;
      end else if (mTr == 1) begin
        tErr = (mCRun != 10) || (w != 16'hF000);
        mTr = 2; mDRun = 1;
      end else begin
        tErr = (w != 16'hF000) || (mDRun >= 10);
        if (mDRun < 11) mDRun++;
      end
      if (mSince < 8) mSince++;
    end
    e[0] = tErr && alignNext;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic ctrl(input bit pay, input bit [1:0] eop, input bit sop,
                      input bit [7:0] port, input bit bad, input string tag);
    logic [3:0] d;
    d = fold(rotl(mAcc) ^ {pay, eop, sop, port, 4'hF}) ^ {3'b000, bad};
    putWord(1'b1, {pay, eop, sop, port, d}, tag);
  endtask

  task automatic rep(input bit c, input logic [15:0] w, input int n, input string tag);
    for (int i = 0; i < n; i++) putWord(c, w, tag);
  endtask

  // monitor: pops one expected vector per word, samples 5 ns after the edge
  always @(posedge clk) begin
    logic [4:0] got, ex;
    string t;
    #5;
    if (expQ.size() > 0) begin
      ex = expQ.pop_front();
      t = tagQ.pop_front();
      got = {errDip4, errProto, errBurstStart, errSopSpacing, errTraining};
      checks++;
      if (got !== ex) begin
        fails++;
        $display("FAIL %s: got %b expected %b (dip,proto,burst,sop,train)", t, got, ex);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({errDip4, errProto, errBurstStart, errSopSpacing, errTraining} !== 5'b0) begin
      fails++;
      $display("FAIL R1: got %b expected 00000", {errDip4, errProto, errBurstStart, errSopSpacing, errTraining});
    end
    // first SOP after reset, clean packet with good parity
    ctrl(1, 2'b00, 1, 8'h05, 0, "R1 first sop after reset");
    putWord(0, 16'h1234, "R2 data"); putWord(0, 16'h4567, "R2 data");
    putWord(0, 16'h89ab, "R2 data"); putWord(0, 16'hcdef, "R2 data");
    ctrl(1, 2'b01, 0, 8'h05, 0, "R2 good parity eop");
    rep(0, 16'h0, 0, "none");
    ctrl(0, 2'b00, 0, 8'h00, 0, "R10 idle clean");
    ctrl(0, 2'b00, 0, 8'h00, 0, "R10 idle clean");
    // parity failures
    ctrl(1, 2'b00, 0, 8'h03, 1, "R2 bad parity after idle");
    putWord(0, 16'hA5A5, "R2 data"); putWord(0, 16'h0F0F, "R2 data"); putWord(0, 16'h8001, "R2 data");
    ctrl(1, 2'b10, 0, 8'h03, 1, "R2 bad parity after data");
    ctrl(0, 2'b00, 0, 8'h00, 0, "R2 idle good parity");
    // payload control pairs
    ctrl(1, 2'b00, 0, 8'h07, 0, "R3 first payload");
    ctrl(1, 2'b00, 0, 8'h02, 0, "R3 payload after payload");
    putWord(0, 16'h5555, "R3 data closes pair");
    ctrl(1, 2'b00, 0, 8'h02, 0, "R3 payload after data ok");
    // data without opened burst
    ctrl(0, 2'b00, 0, 8'h00, 0, "R4 idle");
    putWord(0, 16'h1234, "R4 data after idle"); putWord(0, 16'h4567, "R4 data after idle");
    // sop spacing
    rep(1, 16'h0, 0, "none");
    ctrl(0, 2'b00, 0, 8'h00, 0, "R5 idle");
    ctrl(1, 2'b00, 1, 8'h01, 0, "R5 sop");
    putWord(0, 16'h1111, "R5 data"); putWord(0, 16'h2222, "R5 data");
    ctrl(1, 2'b00, 1, 8'h01, 0, "R5 sop gap 3");
    rep(0, 16'h3333, 7, "R5 data");
    ctrl(1, 2'b00, 1, 8'h01, 0, "R5 sop gap 8");
    rep(0, 16'h4444, 6, "R5 data");
    ctrl(1, 2'b00, 1, 8'h01, 0, "R5 sop gap 7");
    putWord(0, 16'h5555, "R5 data");
    ctrl(0, 2'b11, 0, 8'h00, 0, "R5 idle");
    // training: good
    rep(1, 16'h0FFF, 10, "R6 good ctrl run");
    rep(0, 16'hF000, 10, "R8 good data run");
    ctrl(0, 2'b00, 0, 8'h00, 0, "R8 idle after good training");
    // training: control run 9 and 11
    rep(1, 16'h0FFF, 9, "R6 ctrl run 9");
    rep(0, 16'hF000, 10, "R6 data after short ctrl run");
    rep(1, 16'h0FFF, 11, "R6 ctrl run 11");
    rep(0, 16'hF000, 10, "R6 data after long ctrl run");
    // training: bad data value
    rep(1, 16'h0FFF, 10, "R7 ctrl run");
    rep(0, 16'hF000, 3, "R7 data");
    putWord(0, 16'h000F, "R7 corrupted training data");
    rep(0, 16'hF000, 6, "R7 data");
    // training: data run 11, then 5
    rep(1, 16'h0FFF, 10, "R8 ctrl run");
    rep(0, 16'hF000, 11, "R8 data run 11");
    rep(1, 16'h0FFF, 10, "R8 ctrl run");
    rep(0, 16'hF000, 5, "R8 data run 5");
    ctrl(0, 2'b00, 0, 8'h00, 0, "R8 control cuts data run");
    // not aligned: faults ignored, still tracked
    alignNext = 1'b0;
    rep(1, 16'h0FFF, 9, "R9 ctrl run 9 unaligned");
    rep(0, 16'h000F, 5, "R9 bad data unaligned");
    ctrl(0, 2'b00, 0, 8'h00, 0, "R9 short run unaligned");
    alignNext = 1'b1;
    // several errors on one word
    ctrl(1, 2'b00, 1, 8'h02, 0, "R10 sop");
    ctrl(1, 2'b00, 1, 8'h02, 1, "R10 parity+proto+sop together");
    putWord(0, 16'h6789, "R10 data");
    ctrl(0, 2'b00, 0, 8'h00, 0, "R10 idle");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule